// File: doc/BRIEF.md
# Legacy Configuration Port with Key Unlock

This block implements a two-byte configuration window on a host I/O bus. One address acts as an index port and the next address acts as a data port. A write to the index port chooses a configuration register. A data-port read or write then reaches the register that was chosen. The whole space starts out locked. It opens only after the host writes a fixed four-byte key to the index port. It locks again when the host issues a dedicated exit command.

While the space is open, the host can read a small set of global registers, which hold the chip identity and revision. It can also write a logical device number that picks one of several device register banks. Any index at or above 0x30 belongs to the banked region. Writes to that region are sent to attached function blocks as a one-cycle strobe, together with the device number, the index and the data byte. Reads in that region return the byte those blocks supply.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked. While locked, a read of either port returns 0xFF.
- R2: The space opens once the bytes 0x87, 0x01, 0x55 and 0x55 have been written to the index port as four consecutive index-port writes. Once open, an index-port read returns the last index written.
- R3: A wrong byte in the key restarts matching from the first key byte. A wrong byte that equals 0x87 counts as a new first key byte, so 0x87, 0x01, 0x55, 0x87, 0x01, 0x55, 0x55 opens the space, while 0x87, 0x01, 0x00, 0x55, 0x55 does not.
- R4: While locked, data-port writes are ignored. Key bytes written to the data port do not open the space, and they raise no bank strobe.
- R5: Register 0x07 holds the logical device number. It is readable and writable, it resets to 0x00, and it keeps its value across a relock.
- R6: With a device present, register 0x20 returns the high byte and register 0x21 the low byte of the 16-bit identifier parameter.
- R7: With a device present, register 0x22 returns the 4-bit revision parameter in bits 3:0, with bits 7:4 reading as zero.
- R8: When the device-present parameter is 0, registers 0x20 and 0x21 read 0xFF each, so the identifier reads 0xFFFF, and register 0x22 also reads 0xFF.
- R9: A data-port write of 0x02 while the index is 0x02 relocks the space. Any other value written at index 0x02 leaves the space open. The index is kept across the relock.
- R10: An open data-port write to an index of 0x30 or above raises the bank write strobe for exactly one cycle, starting on the clock edge after the write. During that cycle the bank outputs carry the device number, the index and the data byte. An index of 0x2F or below raises no strobe.
- R11: An open data-port read at an index of 0x30 or above returns the bank read byte. A global index with no register defined for it reads 0x00.
- R12: Bus cycles to any address other than the index and data ports have no effect. Key bytes written to such an address do not open the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write cycle, one byte per clock |
| io_rd | input | 1 | Host read cycle |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte for the addressed port; 0xFF otherwise |
| bank_rdata | input | 8 | Byte returned by the selected device bank |
| bank_wr | output | 1 | One-cycle bank write strobe |
| bank_ldn | output | 8 | Current logical device number |
| bank_idx | output | 8 | Current configuration index |
| bank_wdata | output | 8 | Byte carried with the bank strobe |

## Verification
The bench builds two instances that share every input. The first is built with a device present, a non-trivial identifier 0xC7A1 and revision 6, so that each identity byte and the nibble mask can be told apart from constant values. The second is built with the device-present parameter cleared, which makes the 0xFFFF identifier and the 0xFF revision readable in the same bus cycles. Both instances keep the default base address 0x2E and a 16-bit address, which leaves an unrelated address free for the decode test.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

    localparam int BYTE_W    = 8;
    localparam int KEY_LEN   = 4;
    localparam int KEY_POS_W = $clog2(KEY_LEN);

    localparam logic [BYTE_W-1:0] REG_EXIT   = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_EXIT   = 8'h02;
    localparam logic [BYTE_W-1:0] REG_LDN    = 8'h07;
    localparam logic [BYTE_W-1:0] REG_ID_HI  = 8'h20;
    localparam logic [BYTE_W-1:0] REG_ID_LO  = 8'h21;
    localparam logic [BYTE_W-1:0] REG_REV    = 8'h22;
    localparam logic [BYTE_W-1:0] BANK_BASE  = 8'h30;
    localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;
    localparam logic [BYTE_W-1:0] EMPTY_BYTE = 8'h00;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_INDEX,
        SEL_DATA
    } port_sel_e;

    typedef struct packed {
        logic                 open;
        logic [KEY_POS_W-1:0] pos;
    } key_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] ldn;
    } glob_state_t;

    typedef struct packed {
        logic              wr;
        logic [BYTE_W-1:0] data;
    } bank_state_t;

    // Unlock key, in the order the bytes must arrive.
    function automatic logic [BYTE_W-1:0] key_byte(input int unsigned pos);
        case (pos)
            0:       key_byte = 8'h87;
            1:       key_byte = 8'h01;
            default: key_byte = 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/sio_key_detect.sv
`timescale 1ns/1ps
module sio_key_detect
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [BYTE_W-1:0] key_in,
    input  logic              exit_cmd,
    output logic              open
);
    localparam logic [KEY_POS_W-1:0] LAST_POS = KEY_POS_W'(KEY_LEN - 1);

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (exit_cmd) begin
            st_d.open = 1'b0;
            st_d.pos  = '0;
        end else if (!st_q.open && key_wr) begin
            if (key_in == key_byte(int'(st_q.pos))) begin
                if (st_q.pos == LAST_POS) begin
                    st_d.open = 1'b1;
                    st_d.pos  = '0;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end else if (key_in == key_byte(0)) begin
                // A mismatching byte may still start a new key.
                st_d.pos = KEY_POS_W'(1);
            end else begin
                st_d.pos = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open = st_q.open;

endmodule

// File: rtl/sio_global_regs.sv
`timescale 1ns/1ps
module sio_global_regs
    import sio_pkg::*;
#(
    parameter logic [15:0] CHIP_ID     = 16'h8A5C,
    parameter logic [3:0]  CHIP_REV    = 4'h1,
    parameter bit          DEV_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  port_sel_e         wsel,
    input  port_sel_e         rsel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] bank_rdata,
    output logic [BYTE_W-1:0] idx,
    output logic [BYTE_W-1:0] ldn,
    output logic              exit_cmd,
    output logic              bank_fwd,
    output logic [BYTE_W-1:0] rdata
);
    localparam logic [15:0]       ID_SEEN  = DEV_PRESENT ? CHIP_ID : 16'hFFFF;
    localparam logic [BYTE_W-1:0] REV_SEEN = DEV_PRESENT ? {4'h0, CHIP_REV} : IDLE_BYTE;

    glob_state_t st_d, st_q;
    logic        data_wr;
    logic        in_bank;

    always_comb begin
        data_wr  = open && (wsel == SEL_DATA);
        in_bank  = (st_q.idx >= BANK_BASE);
        exit_cmd = data_wr && (st_q.idx == REG_EXIT) && (wdata == CMD_EXIT);
        bank_fwd = data_wr && in_bank;

        st_d = st_q;
        if (open && (wsel == SEL_INDEX)) begin
            st_d.idx = wdata;
        end
        if (data_wr && (st_q.idx == REG_LDN)) begin
            st_d.ldn = wdata;
        end
    end

    always_comb begin
        rdata = IDLE_BYTE;
        if (open) begin
            case (rsel)
                SEL_INDEX: rdata = st_q.idx;
                SEL_DATA: begin
                    if (in_bank) begin
                        rdata = bank_rdata;
                    end else begin
                        case (st_q.idx)
                            REG_LDN:   rdata = st_q.ldn;
                            REG_ID_HI: rdata = ID_SEEN[15:8];
                            REG_ID_LO: rdata = ID_SEEN[7:0];
                            REG_REV:   rdata = REV_SEEN;
                            default:   rdata = EMPTY_BYTE;
                        endcase
                    end
                end
                default: rdata = IDLE_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx = st_q.idx;
    assign ldn = st_q.ldn;

endmodule

// File: rtl/sio_bank_port.sv
`timescale 1ns/1ps
module sio_bank_port
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd,
    input  logic [BYTE_W-1:0] wdata,
    output logic              bank_wr,
    output logic [BYTE_W-1:0] bank_wdata
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wr = fwd;
        if (fwd) begin
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_wr    = st_q.wr;
    assign bank_wdata = st_q.data;

endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
    import sio_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter logic [15:0]     CHIP_ID     = 16'h8A5C,
    parameter logic [3:0]      CHIP_REV    = 4'h1,
    parameter bit              DEV_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [7:0]        bank_rdata,
    output logic              bank_wr,
    output logic [7:0]        bank_ldn,
    output logic [7:0]        bank_idx,
    output logic [7:0]        bank_wdata
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1'b1);

    port_sel_e wsel, rsel;
    logic      cfg_open;
    logic      exit_cmd;
    logic      bank_fwd;
    logic [BYTE_W-1:0] cur_idx;

    always_comb begin
        wsel = SEL_NONE;
        rsel = SEL_NONE;
        if (io_addr == BASE_ADDR) begin
            if (io_wr) wsel = SEL_INDEX;
            if (io_rd) rsel = SEL_INDEX;
        end else if (io_addr == DATA_ADDR) begin
            if (io_wr) wsel = SEL_DATA;
            if (io_rd) rsel = SEL_DATA;
        end
    end

    sio_key_detect u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wsel == SEL_INDEX),
        .key_in   (io_wdata),
        .exit_cmd (exit_cmd),
        .open     (cfg_open)
    );

    sio_global_regs #(
        .CHIP_ID     (CHIP_ID),
        .CHIP_REV    (CHIP_REV),
        .DEV_PRESENT (DEV_PRESENT)
    ) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .open       (cfg_open),
        .wsel       (wsel),
        .rsel       (rsel),
        .wdata      (io_wdata),
        .bank_rdata (bank_rdata),
        .idx        (cur_idx),
        .ldn        (bank_ldn),
        .exit_cmd   (exit_cmd),
        .bank_fwd   (bank_fwd),
        .rdata      (io_rdata)
    );

    sio_bank_port u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .fwd        (bank_fwd),
        .wdata      (io_wdata),
        .bank_wr    (bank_wr),
        .bank_wdata (bank_wdata)
    );

    assign bank_idx = cur_idx;

endmodule

// File: rtl/sio_cfg_port_chk.sv
`timescale 1ns/1ps
module sio_cfg_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              bank_wr,
    input logic [7:0]        bank_wdata,
    input logic              cfg_open,
    input logic [7:0]        cur_idx
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1'b1);

    p_locked_reads_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && (io_addr == BASE_ADDR || io_addr == DATA_ADDR))
        |-> (io_rdata == 8'hFF));

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && (io_addr == BASE_ADDR) && (io_wdata == 8'h55)));

    p_strobe_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> $past(cfg_open));

    p_exit_relocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && (io_addr == DATA_ADDR) && (cur_idx == 8'h02) && (io_wdata == 8'h02))
        |=> !cfg_open);

    p_close_only_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> $past(io_wr && (io_addr == DATA_ADDR) && (cur_idx == 8'h02)
                                  && (io_wdata == 8'h02)));

    p_strobe_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> $past(io_wr && (io_addr == DATA_ADDR) && (cur_idx >= 8'h30))
                    && (bank_wdata == $past(io_wdata)));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .bank_wr    (bank_wr),
    .bank_wdata (bank_wdata),
    .cfg_open   (cfg_open),
    .cur_idx    (cur_idx)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

    localparam int          CLK_NS   = 4;
    localparam logic [15:0] A_IDX    = 16'h002E;
    localparam logic [15:0] A_DAT    = 16'h002F;
    localparam logic [15:0] A_OTHER  = 16'h0080;
    localparam logic [15:0] ID       = 16'hC7A1;
    localparam logic [3:0]  REV      = 4'h6;
    localparam logic [7:0]  BANK_RD  = 8'h5A;

    localparam logic [1:0] WI = 2'd0, WD = 2'd1, RI = 2'd2, RD = 2'd3;
    localparam int NV = 54;
    // {requirement, op, write byte, expected read byte}
    localparam logic [21:0] VEC [NV] = '{
        {4'd1,  RI, 8'h00, 8'hFF}, {4'd1,  RD, 8'h00, 8'hFF},          // R1
        {4'd2,  WI, 8'h87, 8'h00}, {4'd2,  WI, 8'h01, 8'h00},          // R2 key
        {4'd2,  WI, 8'h55, 8'h00}, {4'd2,  WI, 8'h55, 8'h00},
        {4'd2,  WI, 8'h20, 8'h00}, {4'd2,  RI, 8'h00, 8'h20},
        {4'd6,  RD, 8'h00, 8'hC7},                                     // R6
        {4'd6,  WI, 8'h21, 8'h00}, {4'd6,  RD, 8'h00, 8'hA1},
        {4'd7,  WI, 8'h22, 8'h00}, {4'd7,  RD, 8'h00, 8'h06},          // R7
        {4'd5,  WI, 8'h07, 8'h00}, {4'd5,  RD, 8'h00, 8'h00},          // R5
        {4'd5,  WD, 8'h05, 8'h00}, {4'd5,  RD, 8'h00, 8'h05},
        {4'd11, WI, 8'h10, 8'h00}, {4'd11, RD, 8'h00, 8'h00},          // R11
        {4'd11, WI, 8'h40, 8'h00}, {4'd11, RD, 8'h00, 8'h5A},
        {4'd9,  WI, 8'h02, 8'h00}, {4'd9,  WD, 8'h01, 8'h00},          // R9
        {4'd9,  RI, 8'h00, 8'h02}, {4'd9,  WD, 8'h02, 8'h00},
        {4'd9,  RD, 8'h00, 8'hFF}, {4'd9,  RI, 8'h00, 8'hFF},
        {4'd3,  WI, 8'h87, 8'h00}, {4'd3,  WI, 8'h01, 8'h00},          // R3 restart
        {4'd3,  WI, 8'h55, 8'h00}, {4'd3,  WI, 8'h87, 8'h00},
        {4'd3,  WI, 8'h01, 8'h00}, {4'd3,  WI, 8'h55, 8'h00},
        {4'd3,  WI, 8'h55, 8'h00}, {4'd3,  RI, 8'h00, 8'h02},
        {4'd9,  WD, 8'h02, 8'h00}, {4'd9,  RI, 8'h00, 8'hFF},
        {4'd3,  WI, 8'h87, 8'h00}, {4'd3,  WI, 8'h01, 8'h00},          // R3 broken
        {4'd3,  WI, 8'h00, 8'h00}, {4'd3,  WI, 8'h55, 8'h00},
        {4'd3,  WI, 8'h55, 8'h00}, {4'd3,  RI, 8'h00, 8'hFF},
        {4'd4,  WD, 8'h87, 8'h00}, {4'd4,  WD, 8'h01, 8'h00},          // R4
        {4'd4,  WD, 8'h55, 8'h00}, {4'd4,  WD, 8'h55, 8'h00},
        {4'd4,  RI, 8'h00, 8'hFF},
        {4'd2,  WI, 8'h87, 8'h00}, {4'd2,  WI, 8'h01, 8'h00},
        {4'd2,  WI, 8'h55, 8'h00}, {4'd2,  WI, 8'h55, 8'h00},
        {4'd5,  WI, 8'h07, 8'h00}, {4'd5,  RD, 8'h00, 8'h05}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  bank_rdata = BANK_RD;
    logic [7:0]  rdata_m, rdata_a;
    logic        bwr_m, bwr_a;
    logic [7:0]  bldn_m, bidx_m, bdat_m, bldn_a, bidx_a, bdat_a;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sio_cfg_port #(.CHIP_ID(ID), .CHIP_REV(REV), .DEV_PRESENT(1'b1)) u_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_m), .bank_rdata(bank_rdata),
        .bank_wr(bwr_m), .bank_ldn(bldn_m), .bank_idx(bidx_m), .bank_wdata(bdat_m));

    sio_cfg_port #(.CHIP_ID(ID), .CHIP_REV(REV), .DEV_PRESENT(1'b0)) u_sio_cfg_port_absent (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_a), .bank_rdata(bank_rdata),
        .bank_wr(bwr_a), .bank_ldn(bldn_a), .bank_idx(bidx_a), .bank_wdata(bdat_a));

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] vm, output logic [7:0] va);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        #1;
        vm    = rdata_m;
        va    = rdata_a;
        io_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic unlock();
        wr(A_IDX, 8'h87);
        wr(A_IDX, 8'h01);
        wr(A_IDX, 8'h55);
        wr(A_IDX, 8'h55);
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] vm, va;
        do_reset();
        check("R1", "bank strobe after reset", {7'd0, bwr_m}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [1:0] op;
            logic [7:0] d, e;
            {rq, op, d, e} = VEC[i];
            case (op)
                WI: wr(A_IDX, d);
                WD: wr(A_DAT, d);
                RI: begin
                    rd(A_IDX, vm, va);
                    check($sformatf("R%0d", rq), $sformatf("table step %0d", i), vm, e);
                end
                default: begin
                    rd(A_DAT, vm, va);
                    check($sformatf("R%0d", rq), $sformatf("table step %0d", i), vm, e);
                end
            endcase
        end

        // R10: bank strobe content, single cycle, region boundary
        wr(A_IDX, 8'h07);
        wr(A_DAT, 8'h03);
        wr(A_IDX, 8'h45);
        wr(A_DAT, 8'hA7);
        check("R10", "strobe high", {7'd0, bwr_m}, 8'h01);
        check("R10", "strobe ldn", bldn_m, 8'h03);
        check("R10", "strobe idx", bidx_m, 8'h45);
        check("R10", "strobe data", bdat_m, 8'hA7);
        @(posedge clk);
        #1;
        check("R10", "strobe one cycle", {7'd0, bwr_m}, 8'h00);
        wr(A_IDX, 8'h2F);
        wr(A_DAT, 8'h11);
        check("R10", "no strobe at 0x2F", {7'd0, bwr_m}, 8'h00);
        wr(A_IDX, 8'h30);
        wr(A_DAT, 8'h22);
        check("R10", "strobe at 0x30", {7'd0, bwr_m}, 8'h01);
        check("R10", "strobe data at 0x30", bdat_m, 8'h22);

        // R8: identity of the instance with no device
        wr(A_IDX, 8'h20);
        rd(A_DAT, vm, va);
        check("R8", "absent id high", va, 8'hFF);
        check("R6", "present id high", vm, 8'hC7);
        wr(A_IDX, 8'h21);
        rd(A_DAT, vm, va);
        check("R8", "absent id low", va, 8'hFF);
        wr(A_IDX, 8'h22);
        rd(A_DAT, vm, va);
        check("R8", "absent revision", va, 8'hFF);

        // R12: other addresses have no effect
        wr(A_OTHER, 8'h07);
        rd(A_IDX, vm, va);
        check("R12", "index unchanged by other address", vm, 8'h22);
        wr(A_IDX, 8'h02);
        wr(A_DAT, 8'h02);
        wr(A_OTHER, 8'h87);
        wr(A_OTHER, 8'h01);
        wr(A_OTHER, 8'h55);
        wr(A_OTHER, 8'h55);
        rd(A_IDX, vm, va);
        check("R12", "key to other address stays locked", vm, 8'hFF);

        // R1 and R5: reset mid-run relocks and clears the device number
        unlock();
        rd(A_IDX, vm, va);
        check("R2", "open before reset", vm, 8'h02);
        do_reset();
        rd(A_IDX, vm, va);
        check("R1", "locked after reset", vm, 8'hFF);
        unlock();
        wr(A_IDX, 8'h07);
        rd(A_DAT, vm, va);
        check("R5", "device number reset value", vm, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule